// File: doc/BRIEF.md
# Processor Interrupt Delivery Controller

This block stands between the interrupt sources of a system and the exception logic of a processor core. It captures three kinds of request: a reset request pulse, a non-maskable request pulse, and a maskable level event that carries a 6-bit level value. Each request is held until the core reaches an instruction boundary, which the core marks with a one-cycle strobe. At that boundary the block picks one request by fixed priority and signals the core.

Reset and non-maskable requests share one exception strobe. A maskable level is written into the interrupt-pending field of the cause register. The level is taken only when the status register's global enable is set and at least one level bit meets a set mask bit. A level that is not taken stays pending and is tried again at every later boundary. A level event whose value is zero acts as an end-of-interrupt: it clears the pending field and drops the request.

Top module: `irq_delivery_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the reset, non-maskable and level pending state, drives `cause_ip_o` to zero and holds both exception strobes low. A boundary after reset produces no exception.
- R2: Requests are only latched when they arrive. They are evaluated at the first `boundary_i` edge after the edge that latched them, so a request that arrives in the same cycle as a boundary waits for the next one. An exception strobe is high only in the cycle after a boundary.
- R3: At a boundary the pending reset request wins over the pending non-maskable request, which wins over a pending level. Exactly one request is acted on per boundary, and at most one of the two strobes is high in a cycle.
- R4: A pending reset request and a pending non-maskable request each give a one-cycle pulse on `rstnmi_exc_o` and then clear their own pending flag. Such a delivery leaves `cause_ip_o` unchanged.
- R5: When a level is evaluated, `cause_ip_o` is loaded with the stored level, with level bit i on pending bit i (6 bits by default).
- R6: A stored non-zero level is accepted when `sr_ie_i` is 1 and `(level & sr_im_i) != 0` at that boundary. Acceptance gives a one-cycle `int_exc_o` pulse and clears the stored level.
- R7: A stored non-zero level that is not accepted stays pending. It is evaluated again at every later boundary until it is accepted or replaced.
- R8: A level event with value zero is an end-of-interrupt. When it is evaluated, `cause_ip_o` becomes zero, no exception is raised, and no level remains pending.
- R9: A level event that arrives while an earlier level is still pending replaces the stored value. A request that arrives in the same cycle its pending flag is cleared by delivery stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | Reset request pulse |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| lvl_evt_i | input | 1 | Level event strobe; `lvl_i` is valid |
| lvl_i | input | 6 | Level value; zero means end-of-interrupt |
| boundary_i | input | 1 | Instruction-boundary strobe |
| sr_ie_i | input | 1 | Status register global interrupt enable |
| sr_im_i | input | 6 | Status register interrupt mask field |
| cause_ip_o | output | 6 | Cause register interrupt-pending field |
| rstnmi_exc_o | output | 1 | Reset/non-maskable exception strobe |
| int_exc_o | output | 1 | Maskable interrupt exception strobe |

## Verification
The assertions assume that `sr_ie_i` and `sr_im_i` are valid in every cycle that carries a boundary. They also assume that request pulses and boundaries are sampled on the clock edge and never arrive during reset expecting to be kept. The stimulus drives every input once per cycle, away from the active edge. It issues reset and non-maskable pulses at a low rate and level events at a moderate rate, with about a quarter of those events being zero. Boundaries arrive at random intervals with random enable and mask values. A reference model in the bench follows the same latch-then-evaluate timing to predict each cycle's outputs.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  typedef enum logic [2:0] {
    ACT_NONE     = 3'd0,
    ACT_RST      = 3'd1,
    ACT_NMI      = 3'd2,
    ACT_LVL_TAKE = 3'd3,
    ACT_LVL_HOLD = 3'd4,
    ACT_LVL_EOI  = 3'd5
  } irqd_act_e;

endpackage

// File: rtl/irqd_pending.sv
module irqd_pending #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_req_i,
  input  logic             nmi_req_i,
  input  logic             lvl_evt_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             clr_rst_i,
  input  logic             clr_nmi_i,
  input  logic             clr_lvl_i,
  output logic             pend_rst_o,
  output logic             pend_nmi_o,
  output logic             pend_vld_o,
  output logic [LVL_W-1:0] pend_lvl_o
);

  // Clear first, set afterwards: a fresh request beats its own delivery.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_rst_o <= 1'b0;
      pend_nmi_o <= 1'b0;
      pend_vld_o <= 1'b0;
      pend_lvl_o <= '0;
    end else begin
      if (clr_rst_i) pend_rst_o <= 1'b0;
      if (clr_nmi_i) pend_nmi_o <= 1'b0;
      if (clr_lvl_i) pend_vld_o <= 1'b0;
      if (rst_req_i) pend_rst_o <= 1'b1;
      if (nmi_req_i) pend_nmi_o <= 1'b1;
      if (lvl_evt_i) begin
        pend_vld_o <= 1'b1;
        pend_lvl_o <= lvl_i;
      end
    end
  end

  // A pending reset request is kept until delivered.
  p_rst_held_r4: assert property (@(posedge clk) disable iff (rst)
    (pend_rst_o && !clr_rst_i) |=> pend_rst_o);

  // A newer level event overwrites the stored level.
  p_lvl_replace_r9: assert property (@(posedge clk) disable iff (rst)
    lvl_evt_i |=> (pend_vld_o && pend_lvl_o == $past(lvl_i)));

endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
  import irqd_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             boundary_i,
  input  logic             pend_rst_i,
  input  logic             pend_nmi_i,
  input  logic             pend_vld_i,
  input  logic [LVL_W-1:0] pend_lvl_i,
  input  logic             sr_ie_i,
  input  logic [LVL_W-1:0] sr_im_i,
  output irqd_act_e        act_o,
  output logic             clr_rst_o,
  output logic             clr_nmi_o,
  output logic             clr_lvl_o
);

  logic [LVL_W-1:0] hit;
  logic             any_hit;
  logic             lvl_zero;

  for (genvar i = 0; i < LVL_W; i++) begin : g_hit
    assign hit[i] = pend_lvl_i[i] & sr_im_i[i];
  end

  assign any_hit  = |hit;
  assign lvl_zero = (pend_lvl_i == '0);

  always_comb begin
    act_o = ACT_NONE;
    if (boundary_i) begin
      if (pend_rst_i)                  act_o = ACT_RST;
      else if (pend_nmi_i)             act_o = ACT_NMI;
      else if (pend_vld_i) begin
        if (lvl_zero)                  act_o = ACT_LVL_EOI;
        else if (sr_ie_i && any_hit)   act_o = ACT_LVL_TAKE;
        else                           act_o = ACT_LVL_HOLD;
      end
    end
  end

  assign clr_rst_o = (act_o == ACT_RST);
  assign clr_nmi_o = (act_o == ACT_NMI);
  assign clr_lvl_o = (act_o == ACT_LVL_TAKE) || (act_o == ACT_LVL_EOI);

endmodule

// File: rtl/irqd_deliver.sv
module irqd_deliver
  import irqd_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  irqd_act_e        act_i,
  input  logic [LVL_W-1:0] pend_lvl_i,
  output logic [LVL_W-1:0] cause_ip_o,
  output logic             rstnmi_exc_o,
  output logic             int_exc_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_ip_o   <= '0;
      rstnmi_exc_o <= 1'b0;
      int_exc_o    <= 1'b0;
    end else begin
      rstnmi_exc_o <= 1'b0;
      int_exc_o    <= 1'b0;
      case (act_i)
        ACT_RST, ACT_NMI: rstnmi_exc_o <= 1'b1;
        ACT_LVL_TAKE: begin
          cause_ip_o <= pend_lvl_i;
          int_exc_o  <= 1'b1;
        end
        ACT_LVL_HOLD: cause_ip_o <= pend_lvl_i;
        ACT_LVL_EOI:  cause_ip_o <= '0;
        default: ;
      endcase
    end
  end

  p_one_exc_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rstnmi_exc_o, int_exc_o}));

  p_rstnmi_keeps_cause_r4: assert property (@(posedge clk) disable iff (rst)
    rstnmi_exc_o |-> $stable(cause_ip_o));

endmodule

// File: rtl/irq_delivery_ctrl.sv
module irq_delivery_ctrl
  import irqd_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_req_i,
  input  logic             nmi_req_i,
  input  logic             lvl_evt_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             boundary_i,
  input  logic             sr_ie_i,
  input  logic [LVL_W-1:0] sr_im_i,
  output logic [LVL_W-1:0] cause_ip_o,
  output logic             rstnmi_exc_o,
  output logic             int_exc_o
);

  logic             pend_rst, pend_nmi, pend_vld;
  logic [LVL_W-1:0] pend_lvl;
  logic             clr_rst, clr_nmi, clr_lvl;
  irqd_act_e        act;

  irqd_pending #(.LVL_W(LVL_W)) u_pending (
    .clk        (clk),
    .rst        (rst),
    .rst_req_i  (rst_req_i),
    .nmi_req_i  (nmi_req_i),
    .lvl_evt_i  (lvl_evt_i),
    .lvl_i      (lvl_i),
    .clr_rst_i  (clr_rst),
    .clr_nmi_i  (clr_nmi),
    .clr_lvl_i  (clr_lvl),
    .pend_rst_o (pend_rst),
    .pend_nmi_o (pend_nmi),
    .pend_vld_o (pend_vld),
    .pend_lvl_o (pend_lvl)
  );

  irqd_arbiter #(.LVL_W(LVL_W)) u_arbiter (
    .boundary_i (boundary_i),
    .pend_rst_i (pend_rst),
    .pend_nmi_i (pend_nmi),
    .pend_vld_i (pend_vld),
    .pend_lvl_i (pend_lvl),
    .sr_ie_i    (sr_ie_i),
    .sr_im_i    (sr_im_i),
    .act_o      (act),
    .clr_rst_o  (clr_rst),
    .clr_nmi_o  (clr_nmi),
    .clr_lvl_o  (clr_lvl)
  );

  irqd_deliver #(.LVL_W(LVL_W)) u_deliver (
    .clk          (clk),
    .rst          (rst),
    .act_i        (act),
    .pend_lvl_i   (pend_lvl),
    .cause_ip_o   (cause_ip_o),
    .rstnmi_exc_o (rstnmi_exc_o),
    .int_exc_o    (int_exc_o)
  );

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (cause_ip_o == '0 && !rstnmi_exc_o && !int_exc_o));

  p_exc_after_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    (rstnmi_exc_o || int_exc_o) |-> $past(boundary_i));

  p_rst_first_r3: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && pend_rst) |=> (rstnmi_exc_o && !int_exc_o));

  p_accept_enabled_r6: assert property (@(posedge clk) disable iff (rst)
    int_exc_o |-> ($past(sr_ie_i) && ((cause_ip_o & $past(sr_im_i)) != '0)));

  p_masked_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && !pend_rst && !pend_nmi && pend_vld && pend_lvl != '0 && !sr_ie_i)
    |=> (pend_vld && !int_exc_o && cause_ip_o == $past(pend_lvl)));

  p_eoi_r8: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && !pend_rst && !pend_nmi && pend_vld && pend_lvl == '0 && !lvl_evt_i)
    |=> (cause_ip_o == '0 && !int_exc_o && !pend_vld));

endmodule

// File: tb/irq_delivery_ctrl_bench.sv
module irq_delivery_ctrl_bench;

  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rst_req = 1'b0, nmi_req = 1'b0, lvl_evt = 1'b0, bnd = 1'b0, ie = 1'b0;
  logic [W-1:0] lvl = '0, im = '0;
  logic [W-1:0] cause;
  logic         rn_exc, int_exc;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic         m_prst, m_pnmi, m_pvld;
  logic [W-1:0] m_plvl, m_cause;
  logic         e_rn, e_int;

  always #2 clk = ~clk;

  irq_delivery_ctrl #(.LVL_W(W)) u_irq_delivery_ctrl (
    .clk(clk), .rst(rst), .rst_req_i(rst_req), .nmi_req_i(nmi_req),
    .lvl_evt_i(lvl_evt), .lvl_i(lvl), .boundary_i(bnd), .sr_ie_i(ie),
    .sr_im_i(im), .cause_ip_o(cause), .rstnmi_exc_o(rn_exc), .int_exc_o(int_exc)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // model step: evaluate pending state at a boundary, then latch new requests
  function automatic void model_step(input logic r, input logic n, input logic e,
                                     input logic [W-1:0] l, input logic b,
                                     input logic en, input logic [W-1:0] m);
    e_rn = 1'b0; e_int = 1'b0;
    if (b) begin
      if (m_prst) begin e_rn = 1'b1; m_prst = 1'b0; end
      else if (m_pnmi) begin e_rn = 1'b1; m_pnmi = 1'b0; end
      else if (m_pvld) begin
        m_cause = m_plvl;
        if (m_plvl == '0) m_pvld = 1'b0;
        else if (en && ((m_plvl & m) != '0)) begin e_int = 1'b1; m_pvld = 1'b0; end
      end
    end
    if (r) m_prst = 1'b1;
    if (n) m_pnmi = 1'b1;
    if (e) begin m_pvld = 1'b1; m_plvl = l; end
  endfunction

  task automatic cyc(input logic r, input logic n, input logic e, input logic [W-1:0] l,
                     input logic b, input logic en, input logic [W-1:0] m, input string tag);
    rst_req = r; nmi_req = n; lvl_evt = e; lvl = l; bnd = b; ie = en; im = m;
    model_step(r, n, e, l, b, en, m);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rstnmi_exc", int'(rn_exc), int'(e_rn));
    chk(tag, "int_exc", int'(int_exc), int'(e_int));
    chk(tag, "cause_ip", int'(cause), int'(m_cause));
  endtask

  task automatic do_reset();
    rst = 1'b1; rst_req = 0; nmi_req = 0; lvl_evt = 0; bnd = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_prst = 0; m_pnmi = 0; m_pvld = 0; m_plvl = '0; m_cause = '0;
    chk("R1", "cause after reset", int'(cause), 0);
    chk("R1", "strobes after reset", int'({rn_exc, int_exc}), 0);
  endtask

  initial begin
    #700000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    m_prst = 0; m_pnmi = 0; m_pvld = 0; m_plvl = '0; m_cause = '0;
    @(negedge clk);
    do_reset();
    cyc(0,0,0,6'h00,1,1,6'h3F,"R1");

    // R2: held until boundary; same-cycle request waits
    cyc(0,1,0,6'h00,0,0,6'h00,"R2");
    cyc(0,0,0,6'h00,0,0,6'h00,"R2");
    cyc(0,0,0,6'h00,0,0,6'h00,"R2");
    cyc(0,0,0,6'h00,1,0,6'h00,"R2");
    cyc(0,0,0,6'h00,1,0,6'h00,"R4");
    cyc(0,1,0,6'h00,1,0,6'h00,"R2");
    cyc(0,0,0,6'h00,1,0,6'h00,"R2");

    // R3: priority reset > nmi > level
    cyc(1,1,1,6'h03,0,1,6'h3F,"R3");
    cyc(0,0,0,6'h00,1,1,6'h3F,"R3");
    cyc(0,0,0,6'h00,1,1,6'h3F,"R3");
    cyc(0,0,0,6'h00,1,1,6'h3F,"R5");
    cyc(0,0,0,6'h00,1,1,6'h3F,"R6");

    // R7: masked level stays pending until the mask opens
    cyc(0,0,1,6'h10,0,1,6'h0F,"R7");
    cyc(0,0,0,6'h00,1,1,6'h0F,"R7");
    cyc(0,0,0,6'h00,1,1,6'h0F,"R7");
    cyc(0,0,0,6'h00,1,0,6'h10,"R7");
    cyc(0,0,0,6'h00,1,1,6'h10,"R7");
    cyc(0,0,0,6'h00,1,1,6'h3F,"R6");

    // R8: end-of-interrupt
    cyc(0,0,1,6'h04,0,1,6'h00,"R8");
    cyc(0,0,0,6'h00,1,1,6'h00,"R8");
    cyc(0,0,1,6'h00,0,1,6'h00,"R8");
    cyc(0,0,0,6'h00,1,1,6'h3F,"R8");
    cyc(0,0,0,6'h00,1,1,6'h3F,"R8");

    // R9: replacement and set-beats-clear
    cyc(0,0,1,6'h01,0,1,6'h01,"R9");
    cyc(0,0,1,6'h20,0,1,6'h01,"R9");
    cyc(0,0,0,6'h00,1,1,6'h01,"R9");
    cyc(0,0,0,6'h00,1,1,6'h20,"R9");
    cyc(0,1,0,6'h00,0,0,6'h00,"R9");
    cyc(0,1,0,6'h00,1,0,6'h00,"R9");
    cyc(0,0,0,6'h00,1,0,6'h00,"R9");

    // R1: reset drops pending work
    cyc(0,1,1,6'h07,1,0,6'h00,"R1");
    cyc(1,0,1,6'h05,0,0,6'h00,"R1");
    do_reset();
    cyc(0,0,0,6'h00,1,1,6'h3F,"R1");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic r, n, e, b, en;
      logic [W-1:0] l, m;
      r  = ($urandom % 40) == 0;
      n  = ($urandom % 30) == 0;
      e  = ($urandom % 6) == 0;
      l  = (($urandom % 4) == 0) ? '0 : W'($urandom);
      b  = ($urandom % 3) == 0;
      en = $urandom % 2;
      m  = W'($urandom);
      cyc(r, n, e, l, b, en, m, "R3");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule